// File: doc/BRIEF.md
# Completion ring arm controller

This block holds the control state of one completion or event ring and decides when the ring raises a notification. Software reaches it through a small register window. Two words hold the ring's base address. A control word accepts command codes that set the log2 ring size, the target event-queue or interrupt number, both ring pointers, the enable flag and the arm flag. A read of the same word returns status. A pointer word reads back the producer and consumer positions.

On the hardware side, a writer offers one new ring entry per cycle on a valid/ready pair. Each accepted entry advances the producer pointer. The block refuses entries while the ring is full or disabled. When the ring is enabled and armed and holds unconsumed entries, the block raises a one-cycle notification that carries the target number, and it drops the arm flag. Software then consumes entries. It can move the consumer pointer and re-arm in a single command word. The block does not write ring entries to memory.

Top module: `cq_arm_ctrl`

## Requirements
- R1: After reset, every readable word returns zero, `notify_valid` is low and `hw_wr_ready` is low.
- R2: A write to offset 0x00 stores the low base word with bits [11:0] forced to zero. A write to offset 0x04 stores the high base word unchanged. Both read back at their own offsets.
- R3: Command 0x8080_xxxx written to offset 0x08 loads the producer pointer from data[15:0]. Command 0x8090_xxxx loads the consumer pointer from data[15:0]. Offset 0x0C reads the producer pointer in bits [15:0] and the consumer pointer in bits [31:16].
- R4: Command 0x4000_01xx sets enable from data[0], and command 0x4000_02xx sets the arm flag from data[0]. A read of offset 0x08 shows enable in bit 16 and armed in bit 17.
- R5: Command 0x8002_xxxx sets the log2 ring size from data[3:0]. `hw_wr_ready` is high only while the ring is enabled and the occupancy (producer minus consumer, modulo 2^16) is below 2^log2size. Each cycle with `hw_wr_valid` and `hw_wr_ready` both high advances the producer pointer by one, wrapping from 0xFFFF to 0x0000.
- R6: When the occupancy equals the ring size, `hw_wr_ready` is low and offered entries leave the producer pointer unchanged.
- R7: Any command with data[31:30] = 2'b11 sets the target number from data[15:0]. When the ring is enabled and armed and the two pointers differ, `notify_valid` is high for exactly one cycle with `notify_target` equal to the target, and the arm flag clears.
- R8: Arming while the pointers already differ raises `notify_valid` in the cycle right after the arm write.
- R9: Command 0x8091_xxxx loads the consumer pointer from data[15:0] and sets the arm flag in one write. If the new consumer equals the producer, no notification occurs and the flag stays set until a later entry arrives.
- R10: While the ring is disabled, or while the pointers are equal, an armed ring raises no notification and keeps its arm flag. Enabling it later with entries pending notifies in the following cycle.
- R11: Bit 19 of offset 0x08 reads high exactly when the ring is enabled and the pointers differ.
- R12: Writes to offset 0x0C and control words that match no command change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write byte offset |
| wr_data | input | 32 | Register write data or command word |
| rd_addr | input | 8 | Register read byte offset |
| rd_data | output | 32 | Read data for `rd_addr` (combinational) |
| hw_wr_valid | input | 1 | Hardware offers one new ring entry |
| hw_wr_ready | output | 1 | Ring can take the offered entry |
| notify_valid | output | 1 | One-cycle notification toward the target |
| notify_target | output | TGT_W | Target event-queue or interrupt number |

## Verification
The bench goes after the arm flag's edges. A notification that lasts more than one cycle means the arm clear was lost. A combined consume-and-arm that fires on equal pointers means the design compares stale pointers. A disabled ring that notifies, or that drops its arm flag, would lose the interrupt once software enables it again. The full boundary is hit exactly at occupancy equal to size, and the producer pointer is driven across its 16-bit wrap. Either an off-by-one in the occupancy compare or a wrong carry then appears as an extra accepted entry or a refused one. Alongside the directed steps, a pseudo-random mix of commands and entry offers runs against a behavioural model on every cycle.

// File: rtl/cq_arm_pkg.sv
package cq_arm_pkg;
  localparam logic [7:0] OFS_BASE_LO = 8'h00;
  localparam logic [7:0] OFS_BASE_HI = 8'h04;
  localparam logic [7:0] OFS_CSR     = 8'h08;
  localparam logic [7:0] OFS_PTR     = 8'h0C;

  localparam int PAGE_BITS = 12;
  localparam int BIT_EN    = 16;
  localparam int BIT_ARM   = 17;
  localparam int BIT_ACT   = 19;
  localparam int CONS_LSB  = 16;

  typedef struct packed {
    logic        base_lo;
    logic        base_hi;
    logic        set_log;
    logic        set_tgt;
    logic        set_prod;
    logic        set_cons;
    logic        set_en;
    logic        set_arm;
    logic        arm_val;
    logic [31:0] arg;
  } cq_cmd_t;
endpackage

// File: rtl/cq_cmd_decode.sv
module cq_cmd_decode
  import cq_arm_pkg::*;
(
  input  logic        wr_valid,
  input  logic [7:0]  wr_addr,
  input  logic [31:0] wr_data,
  output cq_cmd_t     cmd
);
  logic csr_wr;

  always_comb begin
    cmd         = '0;
    cmd.arg     = wr_data;
    csr_wr      = wr_valid && (wr_addr == OFS_CSR);
    cmd.base_lo = wr_valid && (wr_addr == OFS_BASE_LO);
    cmd.base_hi = wr_valid && (wr_addr == OFS_BASE_HI);
    if (csr_wr) begin
      if (wr_data[31:30] == 2'b11) begin
        cmd.set_tgt = 1'b1;
      end else begin
        case (wr_data[31:16])
          16'h8002: cmd.set_log  = 1'b1;
          16'h8080: cmd.set_prod = 1'b1;
          16'h8090: cmd.set_cons = 1'b1;
          16'h8091: begin
            cmd.set_cons = 1'b1;
            cmd.set_arm  = 1'b1;
            cmd.arm_val  = 1'b1;
          end
          16'h4000: begin
            case (wr_data[15:8])
              8'h01: cmd.set_en = 1'b1;
              8'h02: begin
                cmd.set_arm = 1'b1;
                cmd.arm_val = wr_data[0];
              end
              default: ;
            endcase
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/cq_ring_state.sv
module cq_ring_state
  import cq_arm_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int TGT_W = 16,
  parameter int LOG_W = $clog2(PTR_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  cq_cmd_t                cmd,
  input  logic                   hw_wr_valid,
  output logic                   hw_wr_ready,
  output logic [31-PAGE_BITS:0]  base_lo,
  output logic [31:0]            base_hi,
  output logic [TGT_W-1:0]       tgt,
  output logic                   en,
  output logic [PTR_W-1:0]       prod,
  output logic [PTR_W-1:0]       cons
);
  logic [31-PAGE_BITS:0] base_lo_q;
  logic [31:0]           base_hi_q;
  logic [LOG_W-1:0]      log_q;
  logic [TGT_W-1:0]      tgt_q;
  logic                  en_q;
  logic [PTR_W-1:0]      prod_q, prod_d, cons_q;
  logic [PTR_W-1:0]      occ;
  logic [PTR_W:0]        ring_size;
  logic                  push, prod_ce;

  always_comb begin
    occ         = prod_q - cons_q;
    ring_size   = {{PTR_W{1'b0}}, 1'b1} << log_q;
    hw_wr_ready = en_q && ({1'b0, occ} < ring_size);
    push        = hw_wr_valid && hw_wr_ready;
    prod_ce     = cmd.set_prod || push;
    prod_d      = cmd.set_prod ? cmd.arg[PTR_W-1:0] : prod_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_lo_q <= '0;
      base_hi_q <= '0;
      log_q     <= '0;
      tgt_q     <= '0;
      en_q      <= 1'b0;
      prod_q    <= '0;
      cons_q    <= '0;
    end else begin
      if (cmd.base_lo) base_lo_q <= cmd.arg[31:PAGE_BITS];
      if (cmd.base_hi) base_hi_q <= cmd.arg;
      if (cmd.set_log) log_q     <= cmd.arg[LOG_W-1:0];
      if (cmd.set_tgt) tgt_q     <= cmd.arg[TGT_W-1:0];
      if (cmd.set_en)  en_q      <= cmd.arg[0];
      if (prod_ce)     prod_q    <= prod_d;
      if (cmd.set_cons) cons_q   <= cmd.arg[PTR_W-1:0];
    end
  end

  assign base_lo = base_lo_q;
  assign base_hi = base_hi_q;
  assign tgt     = tgt_q;
  assign en      = en_q;
  assign prod    = prod_q;
  assign cons    = cons_q;
endmodule

// File: rtl/cq_arm_notify.sv
module cq_arm_notify #(
  parameter int PTR_W = 16,
  parameter int TGT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_arm,
  input  logic             arm_val,
  input  logic             en,
  input  logic [PTR_W-1:0] prod,
  input  logic [PTR_W-1:0] cons,
  input  logic [TGT_W-1:0] tgt,
  output logic             armed,
  output logic             notify_valid,
  output logic [TGT_W-1:0] notify_target
);
  logic armed_q, armed_d, armed_ce, fire;

  always_comb begin
    fire     = armed_q && en && (prod != cons);
    armed_ce = set_arm || fire;
    armed_d  = set_arm ? arm_val : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
    end else if (armed_ce) begin
      armed_q <= armed_d;
    end
  end

  assign armed         = armed_q;
  assign notify_valid  = fire;
  assign notify_target = tgt;
endmodule

// File: rtl/cq_arm_ctrl.sv
module cq_arm_ctrl
  import cq_arm_pkg::*;
#(
  parameter int PTR_W = 16,
  parameter int TGT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_valid,
  input  logic [7:0]       wr_addr,
  input  logic [31:0]      wr_data,
  input  logic [7:0]       rd_addr,
  output logic [31:0]      rd_data,
  input  logic             hw_wr_valid,
  output logic             hw_wr_ready,
  output logic             notify_valid,
  output logic [TGT_W-1:0] notify_target
);
  localparam int LOG_W = $clog2(PTR_W);

  cq_cmd_t               cmd;
  logic [31-PAGE_BITS:0] base_lo;
  logic [31:0]           base_hi;
  logic [TGT_W-1:0]      tgt;
  logic                  en, armed;
  logic [PTR_W-1:0]      prod_q, cons_q;

  cq_cmd_decode u_dec (
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .cmd      (cmd)
  );

  cq_ring_state #(.PTR_W(PTR_W), .TGT_W(TGT_W), .LOG_W(LOG_W)) u_state (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd         (cmd),
    .hw_wr_valid (hw_wr_valid),
    .hw_wr_ready (hw_wr_ready),
    .base_lo     (base_lo),
    .base_hi     (base_hi),
    .tgt         (tgt),
    .en          (en),
    .prod        (prod_q),
    .cons        (cons_q)
  );

  cq_arm_notify #(.PTR_W(PTR_W), .TGT_W(TGT_W)) u_arm (
    .clk           (clk),
    .rst_n         (rst_n),
    .set_arm       (cmd.set_arm),
    .arm_val       (cmd.arm_val),
    .en            (en),
    .prod          (prod_q),
    .cons          (cons_q),
    .tgt           (tgt),
    .armed         (armed),
    .notify_valid  (notify_valid),
    .notify_target (notify_target)
  );

  always_comb begin
    rd_data = '0;
    case (rd_addr)
      OFS_BASE_LO: rd_data = {base_lo, {PAGE_BITS{1'b0}}};
      OFS_BASE_HI: rd_data = base_hi;
      OFS_CSR: begin
        rd_data[BIT_EN]  = en;
        rd_data[BIT_ARM] = armed;
        rd_data[BIT_ACT] = en && (prod_q != cons_q);
      end
      OFS_PTR: begin
        rd_data[PTR_W-1:0]           = prod_q;
        rd_data[CONS_LSB +: PTR_W]   = cons_q;
      end
      default: rd_data = '0;
    endcase
  end
endmodule

// File: rtl/cq_arm_ctrl_chk.sv
module cq_arm_ctrl_chk #(
  parameter int PTR_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             wr_valid,
  input logic             hw_wr_valid,
  input logic             hw_wr_ready,
  input logic             notify_valid,
  input logic [PTR_W-1:0] prod,
  input logic [PTR_W-1:0] cons
);
  AST_ONE_SHOT: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid && !wr_valid |=> !notify_valid); // R7
  AST_NOTIFY_HAS_WORK: assert property (@(posedge clk) disable iff (!rst_n)
    notify_valid |-> prod != cons); // R7
  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    hw_wr_valid && hw_wr_ready && !wr_valid |=> prod == $past(prod) + 1'b1); // R5
  AST_REFUSED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !hw_wr_ready && !wr_valid |=> $stable(prod)); // R6
  AST_CONS_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid |=> $stable(cons)); // R3
  AST_QUIET_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_valid && !hw_wr_valid && !notify_valid |=> !notify_valid); // R10
endmodule

bind cq_arm_ctrl cq_arm_ctrl_chk #(.PTR_W(PTR_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .wr_valid     (wr_valid),
  .hw_wr_valid  (hw_wr_valid),
  .hw_wr_ready  (hw_wr_ready),
  .notify_valid (notify_valid),
  .prod         (prod_q),
  .cons         (cons_q)
);

// File: tb/cq_arm_ctrl_bench.sv
`timescale 1ns/100ps
module cq_arm_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_valid;
  logic [7:0]  wr_addr;
  logic [31:0] wr_data;
  logic [7:0]  rd_addr;
  logic [31:0] rd_data;
  logic        hw_wr_valid;
  logic        hw_wr_ready;
  logic        notify_valid;
  logic [15:0] notify_target;

  int    vecs = 0;
  int    fails = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference state
  int m_blo, m_bhi, m_log, m_tgt, m_prod, m_cons;
  bit m_en, m_arm;

  always #2.5 clk = ~clk;

  cq_arm_ctrl u_cq_arm_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_valid      (wr_valid),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data),
    .rd_addr       (rd_addr),
    .rd_data       (rd_data),
    .hw_wr_valid   (hw_wr_valid),
    .hw_wr_ready   (hw_wr_ready),
    .notify_valid  (notify_valid),
    .notify_target (notify_target)
  );

  function automatic bit m_fire();
    return m_en && m_arm && (m_prod != m_cons);
  endfunction

  function automatic bit m_ready();
    return m_en && (((m_prod - m_cons) & 32'hFFFF) < (1 << m_log));
  endfunction

  function automatic logic [31:0] m_rd(input logic [7:0] a);
    logic [31:0] r;
    r = '0;
    case (a)
      8'h00: r = m_blo;
      8'h04: r = m_bhi;
      8'h08: begin
        r[16] = m_en;
        r[17] = m_arm;
        r[19] = m_en && (m_prod != m_cons);
      end
      8'h0C: r = {m_cons[15:0], m_prod[15:0]};
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    bit fire, acc, sarm, aval, sprod;
    if (!rst_n) begin
      m_blo = 0; m_bhi = 0; m_log = 0; m_tgt = 0;
      m_prod = 0; m_cons = 0; m_en = 0; m_arm = 0;
    end else begin
      fire = m_fire();
      acc  = hw_wr_valid && m_ready();
      sarm = 0; aval = 0; sprod = 0;
      if (wr_valid) begin
        if (wr_addr == 8'h00) m_blo = wr_data & 32'hFFFF_F000;
        else if (wr_addr == 8'h04) m_bhi = wr_data;
        else if (wr_addr == 8'h08) begin
          if (wr_data[31:30] == 2'b11) m_tgt = wr_data[15:0];
          else if (wr_data[31:16] == 16'h8002) m_log = wr_data[3:0];
          else if (wr_data[31:16] == 16'h8080) begin m_prod = wr_data[15:0]; sprod = 1; end
          else if (wr_data[31:16] == 16'h8090) m_cons = wr_data[15:0];
          else if (wr_data[31:16] == 16'h8091) begin m_cons = wr_data[15:0]; sarm = 1; aval = 1; end
          else if (wr_data[31:8] == 24'h4000_01) m_en = wr_data[0];
          else if (wr_data[31:8] == 24'h4000_02) begin sarm = 1; aval = wr_data[0]; end
        end
      end
      if (!sprod && acc) m_prod = (m_prod + 1) & 32'hFFFF;
      if (sarm) m_arm = aval;
      else if (fire) m_arm = 0;
    end
  end

  task automatic cmp(input string what, input logic [31:0] got, input logic [31:0] exp);
    vecs++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", cur_req, what, got, exp);
    end
  endtask

  // model comparison on every cycle, after inputs settle
  always begin
    @(negedge clk);
    #1;
    if (rst_n === 1'b1 && !done) begin
      cmp("notify_valid", {31'b0, notify_valid}, {31'b0, m_fire()});
      cmp("notify_target", {16'b0, notify_target}, m_tgt);
      cmp("hw_wr_ready", {31'b0, hw_wr_ready}, {31'b0, m_ready()});
      cmp("rd_data", rd_data, m_rd(rd_addr));
    end
  end

  task automatic idle_inputs();
    wr_valid = 0; wr_addr = 0; wr_data = 0; hw_wr_valid = 0;
  endtask

  task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    idle_inputs();
    wr_valid = 1; wr_addr = a; wr_data = d;
  endtask

  task automatic push();
    @(negedge clk);
    idle_inputs();
    hw_wr_valid = 1;
  endtask

  task automatic peek(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    idle_inputs();
    rd_addr = a;
    #1;
    cur_req = tag;
    cmp("readback", rd_data, exp);
  endtask

  // checks the output in the current cycle, then idles for it
  task automatic note(input bit exp, input string tag);
    @(negedge clk);
    idle_inputs();
    #1;
    cur_req = tag;
    cmp("notify", {31'b0, notify_valid}, {31'b0, exp});
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lf;
    rst_n = 0;
    idle_inputs();
    rd_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    peek(8'h00, 32'h0, "R1");
    peek(8'h04, 32'h0, "R1");
    peek(8'h08, 32'h0, "R1");
    cmp("ready", {31'b0, hw_wr_ready}, 32'h0);
    peek(8'h0C, 32'h0, "R1");
    cmp("notify", {31'b0, notify_valid}, 32'h0);
    // R2 base words
    reg_wr(8'h00, 32'h1234_5FFF);
    reg_wr(8'h04, 32'hDEAD_BEEF);
    peek(8'h00, 32'h1234_5000, "R2");
    peek(8'h04, 32'hDEAD_BEEF, "R2");
    // setup: size 4, target 0x25, enable (R4)
    reg_wr(8'h08, 32'h8002_0002);
    reg_wr(8'h08, 32'hC000_0025);
    reg_wr(8'h08, 32'h4000_0101);
    peek(8'h08, 32'h0001_0000, "R4");
    // R3 pointer loads
    reg_wr(8'h08, 32'h8080_0010);
    reg_wr(8'h08, 32'h8090_0010);
    peek(8'h0C, 32'h0010_0010, "R3");
    // R12 ignored writes
    reg_wr(8'h08, 32'h8070_0005);
    reg_wr(8'h0C, 32'h1234_5678);
    peek(8'h0C, 32'h0010_0010, "R12");
    peek(8'h08, 32'h0001_0000, "R12");
    // R10 armed with equal pointers: no notification
    reg_wr(8'h08, 32'h4000_0201);
    peek(8'h08, 32'h0003_0000, "R4");
    cmp("notify", {31'b0, notify_valid}, 32'h0);
    note(1'b0, "R10");
    // R7 one entry triggers one notification
    push();
    note(1'b1, "R7");
    cmp("target", {16'b0, notify_target}, 32'h25);
    note(1'b0, "R7");
    peek(8'h08, 32'h0009_0000, "R11");
    // R6 fill to size 4
    push(); push(); push();
    peek(8'h0C, 32'h0010_0014, "R6");
    cmp("ready", {31'b0, hw_wr_ready}, 32'h0);
    push();
    peek(8'h0C, 32'h0010_0014, "R6");
    peek(8'h08, 32'h0009_0000, "R11");
    // R8 arm with pending entries
    reg_wr(8'h08, 32'h4000_0201);
    note(1'b1, "R8");
    note(1'b0, "R8");
    // R9 combined consume and arm
    reg_wr(8'h08, 32'h8091_0014);
    peek(8'h08, 32'h0003_0000, "R9");
    cmp("notify", {31'b0, notify_valid}, 32'h0);
    push();
    note(1'b1, "R9");
    // R10 disabled ring keeps its arm
    reg_wr(8'h08, 32'h4000_0100);
    reg_wr(8'h08, 32'h4000_0201);
    peek(8'h08, 32'h0002_0000, "R10");
    cmp("notify", {31'b0, notify_valid}, 32'h0);
    reg_wr(8'h08, 32'h4000_0101);
    note(1'b1, "R10");
    // R5 wrap of producer pointer
    reg_wr(8'h08, 32'h8080_FFFE);
    reg_wr(8'h08, 32'h8090_FFFE);
    push(); push(); push();
    peek(8'h0C, 32'hFFFE_0001, "R5");
    // pseudo-random traffic against the model
    cur_req = "R7";
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      idle_inputs();
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      rd_addr = {4'h0, lf[3:2], 2'b00};
      hw_wr_valid = lf[4];
      if (lf[7:6] == 2'b00) begin
        wr_valid = 1;
        wr_addr = 8'h08;
        case (lf[11:8])
          4'd0, 4'd1: wr_data = 32'h4000_0201;
          4'd2: wr_data = 32'h4000_0200;
          4'd3: wr_data = 32'h4000_0101;
          4'd4: wr_data = 32'h4000_0100;
          4'd5, 4'd6: wr_data = 32'h8090_0000 | ((m_cons + lf[13:12]) & 32'hFFFF);
          4'd7, 4'd8: wr_data = 32'h8091_0000 | ((m_prod - lf[12]) & 32'hFFFF);
          4'd9: wr_data = 32'hC000_0000 | lf[15:8];
          4'd10: wr_data = 32'h8002_0000 | (1 + lf[13:12]);
          4'd11: wr_data = 32'h8080_0000 | lf;
          default: wr_data = 32'h4000_0101;
        endcase
      end
    end
    @(negedge clk);
    idle_inputs();
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule